// File: doc/BRIEF.md
# Compare-Match Timer

An 8-bit up-counter with one compare register and one waveform output. It serves as a periodic event source or a simple square-wave generator. A mode field chooses the counting sequence. In free-running mode the counter wraps at its maximum. In clear-on-compare mode the compare register sets the top of the count. A separate action field decides what the output does when the counter meets the compare value: nothing, toggle, clear or set.

The host reaches the block through a small register bus with a combinational read. Through it the host writes the counter, the compare value and the control fields, fires a force strobe that applies an output action at once, and reads and acknowledges two sticky flags. The flags mark overflow and compare events and drive an external interrupt controller directly. An enable input stands in for a prescaler: the counter moves only on cycles where that input is high.

Top module: `cmp_timer`

## Requirements
- R1: In mode 0, and in the unused modes 1 and 3, every tick cycle adds one to the counter and wraps from 0xFF to 0x00. The counter is never cleared on compare.
- R2: The overflow flag (status bit 0) is set on the edge where a tick moves the counter from 0xFF to 0x00, in any mode. Hardware never clears it.
- R3: In mode 2, a tick cycle on which the counter equals the compare value loads 0 into the counter instead of incrementing it, unless that match is suppressed.
- R4: The compare flag (status bit 1) is set on the edge that ends a tick cycle in which the counter equals the compare value, unless that match is suppressed.
- R5: On a compare match the output follows the action field: 0 leaves it unchanged, 1 toggles it, 2 drives it low, 3 drives it high. The output is low after reset.
- R6: Writing a new action value does not change the output. The new value governs the output from the next match onward.
- R7: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R8: A control write with bit 7 high applies the action value written in that same write to the output at that edge. It neither sets the compare flag nor touches the counter. Bit 7 reads back as 0. When the force coincides with a match, the action is applied only once.
- R9: A counter write loads the value at that edge and takes priority over a tick. The next tick cycle after the write produces no match: no flag, no output action and no clear.
- R10: In cycles without a tick, the counter and flags hold their values, apart from bus writes.
- R11: The registers are: address 0 counter, address 1 compare value, address 2 control (bits 1:0 mode, bits 3:2 action, bit 7 force), address 3 status. Reads are combinational, unused bits read 0, and every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable (prescaler output) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| cmpOut | output | 1 | Waveform output |
| ovfIrq | output | 1 | Overflow flag |
| cmpIrq | output | 1 | Compare flag |

## Verification
A corrupted counter shows on the counter readback at the next sampling point. It then shows again at the following overflow or match, which arrives early or late by as many ticks as the error. A lost or stray suppression bit shows at the first match after a counter write: the compare flag, the output and, in mode 2, the clear all go wrong on that cycle. A wrongly latched action or a doubled force shows on the output at the edge where it is applied.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } act_e;

  localparam logic [1:0] MODE_FREE = 2'd0;
  localparam logic [1:0] MODE_CTC  = 2'd2;

  localparam int REG_CNT  = 0;
  localparam int REG_CMP  = 1;
  localparam int REG_CTRL = 2;
  localparam int REG_STAT = 3;

  localparam int MODE_LSB  = 0;
  localparam int ACT_LSB   = 2;
  localparam int FORCE_BIT = 7;
  localparam int OVF_BIT   = 0;
  localparam int CMPF_BIT  = 1;

  typedef struct packed {
    logic load;
    logic clear;
    logic advance;
  } cnt_strobe_t;

endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] count,
  output logic             hitCmp,
  output logic             atMax
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)               count <= '0;
    else if (strobe.load)    count <= loadVal;
    else if (strobe.clear)   count <= '0;
    else if (strobe.advance) count <= count + 1'b1;
  end

  assign hitCmp = (count == cmpVal);
  assign atMax  = (count == CNT_MAX);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load && !strobe.clear) |=> (count == $past(count) + 1'b1));

  // R9
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past(loadVal)));

endmodule

// File: rtl/cmp_timer_wave.sv
module cmp_timer_wave
  import cmp_timer_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic evt,
  input  act_e code,
  output logic pinOut
);

  logic pinNext;

  always_comb begin
    pinNext = pinOut;
    if (evt) begin
      case (code)
        ACT_TOGGLE: pinNext = ~pinOut;
        ACT_CLEAR:  pinNext = 1'b0;
        ACT_SET:    pinNext = 1'b1;
        default:    pinNext = pinOut;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pinOut <= 1'b0;
    else       pinOut <= pinNext;
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!evt || code == ACT_NONE) |=> $stable(pinOut));

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt && code == ACT_TOGGLE) |=> (pinOut != $past(pinOut)));

endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              hitCmp,
  input  logic              atMax,
  output cnt_strobe_t       strobe,
  output logic [CNT_W-1:0]  cmpVal,
  output logic [CNT_W-1:0]  rdData,
  output logic              waveEvt,
  output act_e              waveCode,
  output logic              ovfFlag,
  output logic              cmpFlag
);

  logic [1:0] modeReg;
  act_e       actReg;
  logic       suppress;

  logic cntWr, cmpWr, ctrlWr, statWr;
  logic forceStrobe, match, ovfSet;

  assign cntWr  = wrEn && (addr == ADDR_W'(REG_CNT));
  assign cmpWr  = wrEn && (addr == ADDR_W'(REG_CMP));
  assign ctrlWr = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign statWr = wrEn && (addr == ADDR_W'(REG_STAT));

  assign forceStrobe = ctrlWr && wrData[FORCE_BIT];
  assign match       = tickEn && !cntWr && !suppress && hitCmp;
  assign ovfSet      = tickEn && !cntWr && atMax;

  always_comb begin
    strobe.load    = cntWr;
    strobe.clear   = match && (modeReg == MODE_CTC);
    strobe.advance = tickEn;
  end

  assign waveEvt  = forceStrobe || match;
  assign waveCode = forceStrobe ? act_e'(wrData[ACT_LSB +: 2]) : actReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal  <= '0;
      modeReg <= MODE_FREE;
      actReg  <= ACT_NONE;
    end else begin
      if (cmpWr) cmpVal <= wrData;
      if (ctrlWr) begin
        modeReg <= wrData[MODE_LSB +: 2];
        actReg  <= act_e'(wrData[ACT_LSB +: 2]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       suppress <= 1'b0;
    else if (cntWr)  suppress <= 1'b1;
    else if (tickEn) suppress <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      ovfFlag <= ovfSet || (ovfFlag && !(statWr && wrData[OVF_BIT]));
      cmpFlag <= match  || (cmpFlag && !(statWr && wrData[CMPF_BIT]));
    end
  end

  logic [CNT_W-1:0] ctrlRd, statRd;

  always_comb begin
    ctrlRd = '0;
    ctrlRd[MODE_LSB +: 2] = modeReg;
    ctrlRd[ACT_LSB +: 2]  = actReg;
    statRd = '0;
    statRd[OVF_BIT]  = ovfFlag;
    statRd[CMPF_BIT] = cmpFlag;
  end

  always_comb begin
    case (addr)
      ADDR_W'(REG_CNT):  rdData = count;
      ADDR_W'(REG_CMP):  rdData = cmpVal;
      ADDR_W'(REG_CTRL): rdData = ctrlRd;
      ADDR_W'(REG_STAT): rdData = statRd;
      default:           rdData = '0;
    endcase
  end

  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cntWr && atMax) |=> (ovfFlag && count == '0));

  // R3
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_CTC && tickEn && !cntWr && !suppress && hitCmp) |=> (count == '0));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(statWr && wrData[OVF_BIT])) |=> ovfFlag);

  // R8
  force_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceStrobe && !tickEn) |=> ($stable(count) && !$rose(cmpFlag)));

  // R9
  supp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && suppress) |=> !$rose(cmpFlag));

  // R10
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWr) |=> $stable(count));

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              cmpOut,
  output logic              ovfIrq,
  output logic              cmpIrq
);

  cnt_strobe_t      strobe;
  logic [CNT_W-1:0] count, cmpVal;
  logic             hitCmp, atMax, waveEvt;
  act_e             waveCode;

  cmp_timer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .count(count), .hitCmp(hitCmp), .atMax(atMax),
    .strobe(strobe), .cmpVal(cmpVal), .rdData(rdData), .waveEvt(waveEvt),
    .waveCode(waveCode), .ovfFlag(ovfIrq), .cmpFlag(cmpIrq)
  );

  cmp_timer_dp #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(wrData),
    .cmpVal(cmpVal), .count(count), .hitCmp(hitCmp), .atMax(atMax)
  );

  cmp_timer_wave wave (
    .clk(clk), .rstN(rstN), .evt(waveEvt), .code(waveCode), .pinOut(cmpOut)
  );

endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       cmpOut, ovfIrq, cmpIrq;

  int errors = 0;
  int checks = 0;

  logic [7:0] eCnt, eCmp;
  logic [1:0] eMode, eAct;
  logic       ePin, eOvf, eCmpF, eSup;
  string      cntTag;

  always #(CLK_NS/2) clk = ~clk;

  cmp_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cmpOut(cmpOut), .ovfIrq(ovfIrq), .cmpIrq(cmpIrq)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic applyAct(input logic pin, input logic [1:0] code);
    case (code)
      2'd1:    return ~pin;
      2'd2:    return 1'b0;
      2'd3:    return 1'b1;
      default: return pin;
    endcase
  endfunction

  task automatic modelStep(input bit tick, input bit we, input logic [1:0] a, input logic [7:0] d);
    bit cntWr, force_, match, ovfSet;
    cntWr  = we && a == 2'd0;
    force_ = we && a == 2'd2 && d[7];
    match  = tick && !cntWr && !eSup && eCnt == eCmp;
    ovfSet = tick && !cntWr && eCnt == 8'hFF;
    if (cntWr) cntTag = "R9";
    else if (eMode == 2'd2) cntTag = "R3";
    else cntTag = "R1";
    if (force_)     ePin = applyAct(ePin, d[3:2]);
    else if (match) ePin = applyAct(ePin, eAct);
    eOvf  = ovfSet || (eOvf  && !(we && a == 2'd3 && d[0]));
    eCmpF = match  || (eCmpF && !(we && a == 2'd3 && d[1]));
    if (cntWr)     eCnt = d;
    else if (tick) eCnt = (eMode == 2'd2 && match) ? 8'd0 : eCnt + 8'd1;
    if (cntWr)     eSup = 1'b1;
    else if (tick) eSup = 1'b0;
    if (we && a == 2'd1) eCmp = d;
    if (we && a == 2'd2) begin eMode = d[1:0]; eAct = d[3:2]; end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    wrEn = 1'b0;
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic doCycle(input bit tick, input bit we, input logic [1:0] a, input logic [7:0] d);
    logic [7:0] v;
    @(negedge clk);
    tickEn = tick; wrEn = we; addr = a; wrData = d;
    modelStep(tick, we, a, d);
    @(posedge clk);
    #5;
    tickEn = 1'b0;
    chk("R5", cmpOut, ePin, "output pin");
    chk("R2", ovfIrq, eOvf, "overflow flag");
    chk("R4", cmpIrq, eCmpF, "compare flag");
    readReg(2'd0, v);
    chk(cntTag, v, eCnt, "counter");
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED1234));
    eCnt = 0; eCmp = 0; eMode = 0; eAct = 0; ePin = 0; eOvf = 0; eCmpF = 0; eSup = 0;
    cntTag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    // R11 reset state
    chk("R11", cmpOut, 0, "reset pin");
    chk("R11", ovfIrq | cmpIrq, 0, "reset flags");
    readReg(2'd0, v); chk("R11", v, 0, "reset counter");
    readReg(2'd2, v); chk("R11", v, 0, "reset control");

    doCycle(0, 1, 2'd1, 8'h05);
    readReg(2'd1, v); chk("R11", v, 8'h05, "compare readback");

    // force toggle with mode 2
    doCycle(0, 1, 2'd2, 8'h86);
    chk("R8", cmpOut, 1, "force toggle applied");
    chk("R8", cmpIrq, 0, "force sets no flag");
    readReg(2'd0, v); chk("R8", v, 0, "force keeps counter");
    readReg(2'd2, v); chk("R11", v, 8'h06, "control readback, force reads 0");

    for (int i = 0; i < 6; i++) doCycle(1, 0, 2'd0, 8'h00);
    chk("R3", cmpIrq, 1, "match flag in mode 2");
    chk("R5", cmpOut, 0, "toggle on match");
    readReg(2'd0, v); chk("R3", v, 0, "clear on compare");

    for (int i = 0; i < 3; i++) doCycle(0, 0, 2'd0, 8'h00);
    readReg(2'd0, v); chk("R10", v, 0, "no tick holds counter");
    chk("R10", cmpIrq, 1, "no tick holds flag");

    doCycle(0, 1, 2'd2, 8'h0E);
    chk("R6", cmpOut, 0, "action write leaves pin");
    for (int i = 0; i < 6; i++) doCycle(1, 0, 2'd0, 8'h00);
    chk("R6", cmpOut, 1, "new action used at next match");

    doCycle(0, 1, 2'd3, 8'h00);
    chk("R7", cmpIrq, 1, "write 0 keeps flag");
    doCycle(0, 1, 2'd3, 8'h02);
    chk("R7", cmpIrq, 0, "write 1 clears flag");

    doCycle(0, 1, 2'd2, 8'h06);
    doCycle(0, 1, 2'd0, 8'h05);
    doCycle(1, 0, 2'd0, 8'h00);
    chk("R9", cmpIrq, 0, "match suppressed after counter write");
    chk("R9", cmpOut, 1, "no action when suppressed");
    readReg(2'd0, v); chk("R9", v, 8'h06, "no clear when suppressed");
    for (int i = 0; i < 250; i++) doCycle(1, 0, 2'd0, 8'h00);
    chk("R2", ovfIrq, 1, "overflow in mode 2 above top");
    readReg(2'd0, v); chk("R2", v, 0, "counter zero at overflow");

    doCycle(0, 1, 2'd0, 8'h04);
    doCycle(1, 0, 2'd0, 8'h00);
    doCycle(1, 1, 2'd2, 8'h86);
    chk("R8", cmpOut, 0, "force plus match toggles once");

    doCycle(0, 1, 2'd2, 8'h00);
    doCycle(0, 1, 2'd0, 8'h04);
    doCycle(1, 0, 2'd0, 8'h00);
    doCycle(1, 0, 2'd0, 8'h00);
    readReg(2'd0, v); chk("R1", v, 8'h06, "mode 0 passes compare");
    doCycle(0, 1, 2'd3, 8'h03);
    doCycle(0, 1, 2'd0, 8'hFE);
    doCycle(1, 0, 2'd0, 8'h00);
    doCycle(1, 0, 2'd0, 8'h00);
    chk("R1", ovfIrq, 1, "mode 0 wrap sets overflow");

    for (int n = 0; n < 3000; n++) begin
      bit         tick, we;
      logic [1:0] a;
      logic [7:0] d;
      int         r;
      tick = ($urandom % 4) != 0;
      r = $urandom % 16;
      we = 1'b1; a = 2'd0; d = 8'd0;
      if (r < 9) we = 1'b0;
      else if (r == 9)  begin a = 2'd0; d = eCmp - 8'($urandom % 4); end
      else if (r == 10) begin a = 2'd0; d = 8'hFC + 8'($urandom % 4); end
      else if (r == 11) begin a = 2'd1; d = 8'($urandom % 32); end
      else if (r < 14)  begin a = 2'd2; d = {($urandom % 5) == 0, 3'b000, 2'($urandom), 2'($urandom)}; end
      else              begin a = 2'd3; d = 8'($urandom % 4); end
      doCycle(tick, we, a, d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule